// File: doc/BRIEF.md
# Cluster Coherency Configuration Register Block

This block is the software-visible configuration window of a coherency unit shared by a cluster of up to four processor cores. It decodes a 256-byte window of 32-bit registers on a simple single-cycle bus. The bus carries a select, a write flag, a byte address, write data, byte write strobes and a requester ID that names the core making each access. Reads return registered data one cycle after the request. Writes take effect at the clock edge on which they are presented.

The block holds one writable global enable bit. It reports the cluster shape through live read-only fields: the core count, the set of cores taking part in symmetric multiprocessing, and whether a dedicated master-port address window exists. It also keeps a per-core write-lock mask. A core loses write access when a zero is written to its bit, and it gets access back only through a reset. Every later register write that carries that core's requester ID is dropped. A requester ID at or above the configured core count is treated as foreign: its writes are dropped and a one-cycle error pulse is raised. Four address-filter window values, plus a filtering-enable flag, are sampled from strap inputs on the first start pulse after reset. They are read back as page-aligned addresses.

Top module: `clu_cfg_regs`

## Requirements
- R1: After a synchronous reset the enable bit and the filtering flag read 0, every access-control bit reads 1 (no core locked), and `err_o` is 0.
- R2: The control word at offset 0x00 has bit 0 = enable, which is read/write and written only when strobe lane 0 is set. Bit 1 = captured filtering flag (read-only). All other bits, including bit 2, read 0 and ignore writes.
- R3: The configuration word at offset 0x04 reads NUM_CORES-1 in bits [1:0]. Bits [7:4] read the present-core mask ANDed with the low four bits of the SMP_MASK parameter. Bits [30:8] and [3:2] read 0.
- R4: Configuration bit 31 reads 1 exactly when both captured master-window values (before alignment) are nonzero.
- R5: The words at offsets 0x40/0x44 (master window low/high) and 0x48/0x4C (peripheral window low/high) return the captured 32-bit value with bits [19:0] cleared. They ignore writes.
- R6: Strap values are captured only on the first start pulse after reset, and later pulses leave them unchanged. Reset clears the filtering flag but keeps the captured window values until the next capture.
- R7: The access-control word at offset 0x50 reads 1 in bit i for each unlocked core i (i = 0..3). A permitted write with strobe lane 0 set locks every core whose data bit is 0. Writing 1 never unlocks. Only reset clears the locks.
- R8: A write whose requester ID names a locked core changes no state. Writes from unlocked cores with an in-range ID proceed.
- R9: A write whose requester ID is at or above NUM_CORES changes no state and makes `err_o` high for exactly the following cycle. Reads and in-range writes never raise `err_o`.
- R10: The word at offset 0x54 always reads 0x00000FFF and ignores writes. Every other offset in the window reads 0 and ignores writes.
- R11: `bus_rdata_o` is updated on the clock edge that samples a read request, and it holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse that triggers strap capture |
| strap_filt_en_i | input | 1 | Strap: address-filtering enable |
| strap_mst_lo_i | input | 32 | Strap: master window low address |
| strap_mst_hi_i | input | 32 | Strap: master window high address |
| strap_per_lo_i | input | 32 | Strap: peripheral window low address |
| strap_per_hi_i | input | 32 | Strap: peripheral window high address |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_wstrb_i | input | 4 | Byte write strobes |
| bus_rid_i | input | RID_W | Requester core ID |
| bus_rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse for a write from an unknown requester |

## Verification
A lock bit that is set in error, or that clears, is visible at the next read of the access-control word. It also shows up indirectly: the following write from that core either lands or is dropped, which a read of the control word exposes one cycle later. A capture flag that re-arms, or a capture that never happens, shows up on the next read of a window word once the straps have been changed. A wrong write qualification shows up either as an enable bit that changes when it should not or as an error pulse in the cycle after the offending write.

// File: rtl/clu_cfg_pkg.sv
package clu_cfg_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned MAX_CORES = 4;
  localparam int unsigned PAGE_BITS = 20;

  // byte offsets of the decoded words
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_CFG    = 8'h04;
  localparam logic [7:0] OFS_MST_LO = 8'h40;
  localparam logic [7:0] OFS_MST_HI = 8'h44;
  localparam logic [7:0] OFS_PER_LO = 8'h48;
  localparam logic [7:0] OFS_PER_HI = 8'h4C;
  localparam logic [7:0] OFS_ACC    = 8'h50;
  localparam logic [7:0] OFS_NSAC   = 8'h54;

  typedef struct packed {
    logic [REG_W-1:0] mst_lo;
    logic [REG_W-1:0] mst_hi;
    logic [REG_W-1:0] per_lo;
    logic [REG_W-1:0] per_hi;
  } filt_win_t;

  function automatic logic [REG_W-1:0] page_align(input logic [REG_W-1:0] a);
    return {a[REG_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  endfunction

endpackage

// File: rtl/clu_strap_latch.sv
module clu_strap_latch
  import clu_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      strap_en_i,
  input  filt_win_t strap_win_i,
  output logic      filt_en_o,
  output logic      started_o,
  output filt_win_t win_o
);

  logic      started_q;
  logic      filt_en_q;
  filt_win_t win_q;
  logic      take;

  assign take = start_i & ~started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      filt_en_q <= 1'b0;
    end else if (take) begin
      started_q <= 1'b1;
      filt_en_q <= strap_en_i;
    end
  end

  // window values survive reset on purpose: no reset branch
  always_ff @(posedge clk) begin
    if (!rst && take) begin
      win_q <= strap_win_i;
    end
  end

  assign filt_en_o = filt_en_q;
  assign started_o = started_q;
  assign win_o     = win_q;

endmodule

// File: rtl/clu_lock_mask.sv
module clu_lock_mask #(
  parameter int unsigned NUM_LOCKS = 4
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic [NUM_LOCKS-1:0] wdata_i,
  output logic [NUM_LOCKS-1:0] lock_o
);

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    logic lk_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lk_q <= 1'b0;
      end else if (wr_i && !wdata_i[i]) begin
        lk_q <= 1'b1;
      end
    end
    assign lock_o[i] = lk_q;
  end

endmodule

// File: rtl/clu_read_mux.sv
module clu_read_mux
  import clu_cfg_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter logic [7:0]  SMP_MASK  = 8'hFF,
  parameter int unsigned ADDR_W    = 8
)(
  input  logic [ADDR_W-1:0]    word_addr_i,
  input  logic                 en_i,
  input  logic                 filt_en_i,
  input  filt_win_t            win_i,
  input  logic [MAX_CORES-1:0] lock_i,
  output logic [REG_W-1:0]     rd_word_o
);

  localparam logic [MAX_CORES-1:0] PRESENT  = MAX_CORES'((1 << NUM_CORES) - 1);
  localparam logic [3:0]           SMP_FLD  = 4'(PRESENT) & SMP_MASK[3:0];
  localparam logic [1:0]           CNT_FLD  = 2'(NUM_CORES - 1);

  logic mst_both;
  assign mst_both = (win_i.mst_lo != '0) && (win_i.mst_hi != '0);

  always_comb begin
    rd_word_o = '0;
    case (word_addr_i)
      ADDR_W'(OFS_CTRL):   rd_word_o[1:0] = {filt_en_i, en_i};
      ADDR_W'(OFS_CFG): begin
        rd_word_o[1:0]       = CNT_FLD;
        rd_word_o[7:4]       = SMP_FLD;
        rd_word_o[REG_W-1]   = mst_both;
      end
      ADDR_W'(OFS_MST_LO): rd_word_o = page_align(win_i.mst_lo);
      ADDR_W'(OFS_MST_HI): rd_word_o = page_align(win_i.mst_hi);
      ADDR_W'(OFS_PER_LO): rd_word_o = page_align(win_i.per_lo);
      ADDR_W'(OFS_PER_HI): rd_word_o = page_align(win_i.per_hi);
      ADDR_W'(OFS_ACC):    rd_word_o[MAX_CORES-1:0] = ~lock_i;
      ADDR_W'(OFS_NSAC):   rd_word_o[11:0] = '1;
      default:             rd_word_o = '0;
    endcase
  end

endmodule

// File: rtl/clu_cfg_regs.sv
module clu_cfg_regs
  import clu_cfg_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter logic [7:0]  SMP_MASK  = 8'hFF,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RID_W     = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              strap_filt_en_i,
  input  logic [REG_W-1:0]  strap_mst_lo_i,
  input  logic [REG_W-1:0]  strap_mst_hi_i,
  input  logic [REG_W-1:0]  strap_per_lo_i,
  input  logic [REG_W-1:0]  strap_per_hi_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  input  logic [3:0]        bus_wstrb_i,
  input  logic [RID_W-1:0]  bus_rid_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              err_o
);

  localparam int unsigned IDX_W = $clog2(MAX_CORES);

  logic                 wr_req, rd_req;
  logic                 rid_known, rid_locked, wr_ok;
  logic [ADDR_W-1:0]    word_addr;
  logic                 hit_ctrl, hit_acc;
  logic [MAX_CORES-1:0] lock_q;
  logic                 en_q, err_q;
  logic                 filt_en, started_q;
  filt_win_t            strap_win, win_q;
  logic [REG_W-1:0]     rd_word, rdata_q;
  logic                 unused_bits;

  assign wr_req     = bus_sel_i & bus_we_i;
  assign rd_req     = bus_sel_i & ~bus_we_i;
  assign rid_known  = ({1'b0, bus_rid_i} < (RID_W+1)'(NUM_CORES));
  assign rid_locked = lock_q[bus_rid_i[IDX_W-1:0]];
  assign wr_ok      = wr_req & rid_known & ~rid_locked;

  assign word_addr  = {bus_addr_i[ADDR_W-1:2], 2'b00};
  assign hit_ctrl   = (word_addr == ADDR_W'(OFS_CTRL));
  assign hit_acc    = (word_addr == ADDR_W'(OFS_ACC));

  assign strap_win  = '{mst_lo: strap_mst_lo_i, mst_hi: strap_mst_hi_i,
                        per_lo: strap_per_lo_i, per_hi: strap_per_hi_i};

  clu_strap_latch u_strap (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .strap_en_i (strap_filt_en_i),
    .strap_win_i(strap_win),
    .filt_en_o  (filt_en),
    .started_o  (started_q),
    .win_o      (win_q)
  );

  clu_lock_mask #(.NUM_LOCKS(MAX_CORES)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_ok & hit_acc & bus_wstrb_i[0]),
    .wdata_i(bus_wdata_i[MAX_CORES-1:0]),
    .lock_o (lock_q)
  );

  clu_read_mux #(
    .NUM_CORES(NUM_CORES),
    .SMP_MASK (SMP_MASK),
    .ADDR_W   (ADDR_W)
  ) u_rmux (
    .word_addr_i(word_addr),
    .en_i       (en_q),
    .filt_en_i  (filt_en),
    .win_i      (win_q),
    .lock_i     (lock_q),
    .rd_word_o  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (wr_ok && hit_ctrl && bus_wstrb_i[0]) begin
      en_q <= bus_wdata_i[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else begin
      err_q <= wr_req & ~rid_known;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_req) begin
      rdata_q <= rd_word;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign err_o       = err_q;
  assign unused_bits = ^{bus_wdata_i[REG_W-1:MAX_CORES], bus_wstrb_i[3:1],
                         bus_addr_i[1:0], started_q};

endmodule

// File: rtl/clu_cfg_regs_chk.sv
module clu_cfg_regs_chk
  import clu_cfg_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter logic [7:0]  SMP_MASK  = 8'hFF,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RID_W     = 3
)(
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel_i,
  input logic                 bus_we_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [RID_W-1:0]     bus_rid_i,
  input logic [REG_W-1:0]     bus_rdata_o,
  input logic                 err_o,
  input logic [MAX_CORES-1:0] lock_q,
  input logic                 en_q,
  input logic                 started_q,
  input filt_win_t            win_q
);

  localparam logic [3:0] CHK_SMP = 4'((1 << NUM_CORES) - 1) & SMP_MASK[3:0];

  logic rid_out, rid_lk, rd_nsac, rd_cfg;
  assign rid_out = ({1'b0, bus_rid_i} >= (RID_W+1)'(NUM_CORES));
  assign rid_lk  = !rid_out && lock_q[bus_rid_i[1:0]];
  assign rd_nsac = bus_sel_i && !bus_we_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(8'h15));
  assign rd_cfg  = bus_sel_i && !bus_we_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(8'h01));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lock_q == '0) && !en_q && !err_o);

  // R9
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !$past(rst) && $past(bus_sel_i && bus_we_i && rid_out));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R8
  locked_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_sel_i && bus_we_i && rid_lk)) |-> ($stable(en_q) && $stable(lock_q)));

  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(started_q)) |-> $stable(win_q));

  // R10
  nsac_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_nsac)) |-> (bus_rdata_o == 32'h0000_0FFF));

  // R3
  cfg_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_cfg)) |->
      (bus_rdata_o[30:0] == {23'd0, CHK_SMP, 2'b00, 2'(NUM_CORES - 1)}));

endmodule

bind clu_cfg_regs clu_cfg_regs_chk #(
  .NUM_CORES(NUM_CORES),
  .SMP_MASK (SMP_MASK),
  .ADDR_W   (ADDR_W),
  .RID_W    (RID_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_rid_i  (bus_rid_i),
  .bus_rdata_o(bus_rdata_o),
  .err_o      (err_o),
  .lock_q     (lock_q),
  .en_q       (en_q),
  .started_q  (started_q),
  .win_q      (win_q)
);

// File: tb/clu_cfg_regs_tb_top.sv
module clu_cfg_regs_tb_top;

  localparam int unsigned N_CORES = 3;
  localparam logic [7:0]  SMASK   = 8'h0D;   // present 0x7 & 0xD -> 0x5
  localparam logic [31:0] CFG_LO  = 32'h0000_0052;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        s_en = 1'b0;
  logic [31:0] s_mlo = '0, s_mhi = '0, s_plo = '0, s_phi = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [2:0]  bus_rid = '0;
  logic [31:0] bus_rdata;
  logic        err;

  always #5 clk = ~clk;

  clu_cfg_regs #(.NUM_CORES(N_CORES), .SMP_MASK(SMASK), .ADDR_W(8), .RID_W(3)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .strap_filt_en_i(s_en),
    .strap_mst_lo_i(s_mlo), .strap_mst_hi_i(s_mhi),
    .strap_per_lo_i(s_plo), .strap_per_hi_i(s_phi),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_wstrb_i(bus_wstrb), .bus_rid_i(bus_rid),
    .bus_rdata_o(bus_rdata), .err_o(err)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  logic rd_pend = 1'b0;

  function automatic void chk(input bit ok, input string tag,
                              input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endfunction

  // monitor: read issued at a posedge is compared at the next negedge
  always @(posedge clk) rd_pend <= bus_sel && !bus_we && !rst;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R11 unexpected read data", bus_rdata, '0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    sb_q.push_back('{exp: e, tag: t});
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                    input logic [2:0] id, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a;
    bus_wdata = d; bus_wstrb = s; bus_rid = id;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    e = err;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic e;
    s_en = 1'b1; s_mlo = 32'h1234_5678; s_mhi = 32'h0;
    s_plo = 32'hABCD_EF01; s_phi = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R1 err after reset", {31'd0, err}, 32'd0);
    rd(8'h00, 32'h0, "R1 control after reset");
    rd(8'h50, 32'hF, "R1 access control after reset");

    pulse_start();
    rd(8'h00, 32'h2, "R2 filter flag captured");
    rd(8'h04, CFG_LO, "R3 R4 configuration with zero master high");
    rd(8'h40, 32'h1230_0000, "R5 master low aligned");
    rd(8'h44, 32'h0, "R5 master high");
    rd(8'h48, 32'hABC0_0000, "R5 peripheral low aligned");
    rd(8'h4C, 32'hFFF0_0000, "R5 peripheral high aligned");
    @(negedge clk);
    chk(bus_rdata == 32'hFFF0_0000, "R11 read data held while idle", bus_rdata, 32'hFFF0_0000);

    s_mhi = 32'h0020_0000; s_en = 1'b0;
    pulse_start();
    rd(8'h44, 32'h0, "R6 second start does not recapture");
    rd(8'h00, 32'h2, "R6 flag not recaptured");

    wr(8'h40, 32'h0, 4'hF, 3'd0, e);
    rd(8'h40, 32'h1230_0000, "R5 window word ignores write");
    wr(8'h00, 32'hFFFF_FFFF, 4'hF, 3'd0, e);
    chk(e == 1'b0, "R9 no error on in-range write", {31'd0, e}, 32'd0);
    rd(8'h00, 32'h3, "R2 enable set, upper bits stay zero");
    wr(8'h00, 32'h0, 4'hE, 3'd0, e);
    rd(8'h00, 32'h3, "R2 lane 0 strobe clear keeps enable");
    wr(8'h54, 32'h0, 4'hF, 3'd0, e);
    rd(8'h54, 32'h0000_0FFF, "R10 non-secure word fixed");
    wr(8'h30, 32'hFFFF_FFFF, 4'hF, 3'd0, e);
    rd(8'h30, 32'h0, "R10 unmapped offset reads zero");

    wr(8'h00, 32'h0, 4'hF, 3'd3, e);
    chk(e == 1'b1, "R9 error pulse for unknown requester", {31'd0, e}, 32'd1);
    @(negedge clk);
    chk(err == 1'b0, "R9 error pulse lasts one cycle", {31'd0, err}, 32'd0);
    rd(8'h00, 32'h3, "R9 unknown requester write dropped");

    wr(8'h50, 32'hFFFF_FFFD, 4'hF, 3'd0, e);
    rd(8'h50, 32'hD, "R7 zero bit locks core 1");
    wr(8'h00, 32'h0, 4'hF, 3'd1, e);
    chk(e == 1'b0, "R8 locked write raises no error", {31'd0, e}, 32'd0);
    rd(8'h00, 32'h3, "R8 locked core write dropped");
    wr(8'h50, 32'h0, 4'hF, 3'd1, e);
    rd(8'h50, 32'hD, "R8 locked core cannot lock others");
    wr(8'h50, 32'hF, 4'hF, 3'd0, e);
    rd(8'h50, 32'hD, "R7 writing one does not unlock");
    wr(8'h00, 32'h0, 4'hF, 3'd2, e);
    rd(8'h00, 32'h2, "R8 unlocked core write lands");
    wr(8'h00, 32'h1, 4'hF, 3'd7, e);
    chk(e == 1'b1, "R9 error for requester 7", {31'd0, e}, 32'd1);

    s_mlo = 32'h0000_0005; s_mhi = 32'h0020_0000; s_plo = 32'h0; s_en = 1'b1;
    do_reset();
    rd(8'h50, 32'hF, "R1 locks cleared by reset");
    rd(8'h00, 32'h0, "R6 flag cleared by reset");
    rd(8'h48, 32'hABC0_0000, "R6 window kept through reset");
    pulse_start();
    rd(8'h04, 32'h8000_0000 | CFG_LO, "R4 bit 31 uses unaligned values");
    rd(8'h40, 32'h0, "R5 small value aligns to zero");
    rd(8'h48, 32'h0, "R6 capture after reset");
    wr(8'h00, 32'h1, 4'h1, 3'd1, e);
    rd(8'h00, 32'h3, "R7 core 1 writable after reset");

    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R11 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", '0, '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule